// File: doc/BRIEF.md
# Buffered SPI Master with Interrupt Flags

This block is a memory-mapped SPI master that moves bytes from a transmit queue onto the serial bus and collects the bytes that come back into a receive queue. Software talks to it through a 32-bit register port. It can load up to 256 bytes while the engine is held off, then release them in one burst. It reads the replies back one at a time, and it either polls the status word or waits for the single interrupt line.

The serial engine runs SPI mode 0. The clock idles low, data goes out most significant bit first, and the returned line is sampled on each rising edge. Each half period lasts a fixed number of system clocks. The slave selects are plain register bits driven straight to the pins, so software frames each transaction itself. Interrupt flags are sticky, and writing a 1 to a flag inverts it. A soft reset happens only when one key value is written.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the status word reads 0x5, the control word reads 0, the interrupt flags read 0, the select register reads all ones and the irq output is low.
- R2: Register word indexes (byte address bits 5:2) are: 0 control, 1 status, 2 transmit data, 3 receive data, 4 select, 5 interrupt flags, 6 interrupt enables, 7 global enable, 8 soft reset. Status bits are: bit 0 receive queue empty, bit 1 receive queue full, bit 2 transmit queue empty, bit 3 transmit queue full.
- R3: While control bit 8 (hold) is 1, no queued byte is sent. When it is cleared, the queued bytes are sent in the order they were written.
- R4: Writing 0xA to the soft reset word returns every register and both queues to their reset state. Writing any other value there changes nothing.
- R5: Each active-low select pin follows its bit of the select register, so writing 0 to a bit selects that slave.
- R6: Writing the interrupt flag word inverts each implemented flag whose written bit is 1. Bits that are not implemented always read 0.
- R7: Interrupt flag bits are: 2 byte sent, 4 receive queue full, 5 receive overrun, 8 receive queue not empty. irq is high exactly when some flag is set together with its enable bit and bit 31 of the global enable word is 1.
- R8: A byte that arrives while the receive queue is full is dropped and sets flag 5. Reading the receive word from an empty queue returns 0xDEADBEEF. Otherwise it returns the oldest byte in bits 7:0 and removes that byte.
- R9: Each byte is sent in SPI mode 0, most significant bit first: sclk idles low and the master samples miso on each rising edge. Flag 2 is set when a byte finishes.
- R10: Control bit 5 empties the transmit queue and control bit 6 empties the receive queue. Neither bit is stored: both read back as 0.
- R11: Each queue holds 256 bytes. A write to the transmit word while that queue is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access in this cycle |
| reg_wr | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | 6 | Byte address; bits 5:2 select the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as the request |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | NUM_SEL | Active-low slave selects |
| irq | output | 1 | Interrupt request |

## Verification
A queue pointer or count that goes wrong shows up at the ports as a status word that disagrees with the number of bytes written and sent. If it does not show there, it shows as a byte returned out of order, a missing 0xDEADBEEF or a missing overrun flag within one byte time after the queue boundary. A slip in the shift engine corrupts the byte seen on mosi and the reply read back, and both are visible one byte time (about 34 clocks) after the write. Faults in the flags appear on irq in the cycle after the enables are written, because irq is combinational on the stored flags.

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int FIFO_DEPTH = 256,
  parameter int NUM_SEL    = 4,
  parameter int HALF_DIV   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_req,
  input  logic               reg_wr,
  input  logic [5:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               spi_sclk,
  output logic               spi_mosi,
  input  logic               spi_miso,
  output logic [NUM_SEL-1:0] spi_ss_n,
  output logic               irq
);
  localparam int AW = $clog2(FIFO_DEPTH);
  localparam int CW = AW + 1;
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] FULL = CW'(FIFO_DEPTH);
  localparam logic [8:0] FLAG_MASK = 9'h134;

  localparam logic [3:0] W_CTRL = 4'd0, W_STAT = 4'd1, W_TXD = 4'd2, W_RXD = 4'd3,
                         W_SEL = 4'd4, W_FLAG = 4'd5, W_IEN = 4'd6, W_GIE = 4'd7,
                         W_SRST = 4'd8;

  logic [3:0] idx;
  logic wr, rd, soft_hit;
  assign idx      = reg_addr[5:2];
  assign wr       = reg_req & reg_wr;
  assign rd       = reg_req & ~reg_wr;
  assign soft_hit = wr && idx == W_SRST && reg_wdata == 32'hA;

  logic               hold_q, gie_q;
  logic [NUM_SEL-1:0] sel_q;
  logic [8:0]         flag_q, ien_q;

  logic [7:0]    tx_mem [FIFO_DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic [7:0]    rx_mem [FIFO_DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;

  logic          busy, sclk_q;
  logic [2:0]    bit_q;
  logic [DW-1:0] half_q;
  logic [7:0]    sh_tx, sh_rx;

  logic tick, done, start;
  logic tx_push, tx_flush, rx_push, rx_pop, rx_flush, overrun_ev;

  assign tick       = busy && half_q == DW'(HALF_DIV - 1);
  assign done       = tick && sclk_q && bit_q == 3'd7;
  assign start      = !busy && !hold_q && tx_cnt != '0;
  assign tx_push    = wr && idx == W_TXD && tx_cnt != FULL;
  assign tx_flush   = wr && idx == W_CTRL && reg_wdata[5];
  assign rx_flush   = wr && idx == W_CTRL && reg_wdata[6];
  assign rx_push    = done && rx_cnt != FULL;
  assign overrun_ev = done && rx_cnt == FULL;
  assign rx_pop     = rd && idx == W_RXD && rx_cnt != '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold_q <= 1'b0; gie_q <= 1'b0; sel_q <= '1; ien_q <= '0;
    end else if (soft_hit) begin
      hold_q <= 1'b0; gie_q <= 1'b0; sel_q <= '1; ien_q <= '0;
    end else if (wr) begin
      case (idx)
        W_CTRL: hold_q <= reg_wdata[8];
        W_SEL:  sel_q  <= reg_wdata[NUM_SEL-1:0];
        W_IEN:  ien_q  <= reg_wdata[8:0] & FLAG_MASK;
        W_GIE:  gie_q  <= reg_wdata[31];
        default: ;
      endcase
    end

  logic [8:0] flag_ev;
  always_comb begin
    flag_ev    = '0;
    flag_ev[2] = done;
    flag_ev[4] = rx_cnt == FULL;
    flag_ev[5] = overrun_ev;
    flag_ev[8] = rx_cnt != '0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        flag_q <= '0;
    else if (soft_hit) flag_q <= '0;
    else flag_q <= (((wr && idx == W_FLAG) ? flag_q ^ reg_wdata[8:0] : flag_q) | flag_ev) & FLAG_MASK;

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp] <= reg_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (soft_hit || tx_flush) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (start)   tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(start);
    end

  always_ff @(posedge clk)
    if (rx_push) rx_mem[rx_wp] <= sh_rx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (soft_hit || rx_flush) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; sclk_q <= 1'b0; bit_q <= '0; half_q <= '0; sh_tx <= '0; sh_rx <= '0;
    end else if (soft_hit) begin
      busy <= 1'b0; sclk_q <= 1'b0; bit_q <= '0; half_q <= '0; sh_tx <= '0; sh_rx <= '0;
    end else if (start) begin
      busy <= 1'b1; sclk_q <= 1'b0; bit_q <= '0; half_q <= '0; sh_tx <= tx_mem[tx_rp];
    end else if (busy) begin
      if (tick) begin
        half_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          sh_rx  <= {sh_rx[6:0], spi_miso};
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == 3'd7) busy <= 1'b0;
          else begin
            bit_q <= bit_q + 1'b1;
            sh_tx <= {sh_tx[6:0], 1'b0};
          end
        end
      end else half_q <= half_q + 1'b1;
    end

  assign spi_sclk = sclk_q;
  assign spi_mosi = busy & sh_tx[7];
  assign spi_ss_n = sel_q;
  assign irq      = gie_q && |(flag_q & ien_q);

  always_comb begin
    reg_rdata = '0;
    case (idx)
      W_CTRL: reg_rdata[8] = hold_q;
      W_STAT: reg_rdata[3:0] = {tx_cnt == FULL, tx_cnt == '0, rx_cnt == FULL, rx_cnt == '0};
      W_RXD:  reg_rdata = (rx_cnt == '0) ? 32'hDEADBEEF : {24'd0, rx_mem[rx_rp]};
      W_SEL:  reg_rdata[NUM_SEL-1:0] = sel_q;
      W_FLAG: reg_rdata[8:0] = flag_q;
      W_IEN:  reg_rdata[8:0] = ien_q;
      W_GIE:  reg_rdata[31] = gie_q;
      default: ;
    endcase
  end

  AST_SEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == W_SEL) |=> spi_ss_n == $past(reg_wdata[NUM_SEL-1:0])); // R5
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_hit |=> (spi_ss_n == '1 && tx_cnt == '0 && rx_cnt == '0 && !busy)); // R4
  AST_HOLD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !busy && !(wr && idx == W_CTRL)) |=> !busy); // R3
  AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_cnt == FULL && !soft_hit) |=> flag_q[5]); // R8
  AST_BYTE_SENT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !soft_hit) |=> flag_q[2]); // R9
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sclk); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt <= FULL && tx_cnt <= FULL)); // R11
endmodule

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb_top;
  localparam int HALF = 2;
  localparam int BYTE_CYC = 16 * HALF + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_req = 1'b0, reg_wr = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic spi_sclk, spi_mosi, spi_miso, irq;
  logic [3:0] spi_ss_n;

  int n_chk = 0, n_bad = 0;
  logic [7:0] mon_sh = '0;

  always #4 clk = ~clk;
  assign spi_miso = ~spi_mosi;
  always @(posedge spi_sclk) mon_sh <= {mon_sh[6:0], spi_mosi};

  spi_fifo_master #(.FIFO_DEPTH(256), .NUM_SEL(4), .HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_ss_n(spi_ss_n), .irq(irq));

  localparam logic [5:0] A_CTRL = 6'h00, A_STAT = 6'h04, A_TXD = 6'h08, A_RXD = 6'h0C,
                         A_SEL = 6'h10, A_FLAG = 6'h14, A_IEN = 6'h18, A_GIE = 6'h1C,
                         A_SRST = 6'h20;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_req = 1'b0;
  endtask

  task automatic wait_bytes(input int n);
    repeat (n * BYTE_CYC + 8) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_STAT, v); check("R1 status", v, 32'h5);
    rd(A_CTRL, v); check("R1 control", v, 32'h0);
    rd(A_FLAG, v); check("R1 flags", v, 32'h0);
    rd(A_SEL, v);  check("R1 select", v, 32'hF);
    check("R1 irq", {31'd0, irq}, 32'h0);
    check("R5 pins at reset", {28'd0, spi_ss_n}, 32'hF);
  endtask

  task automatic t_basic;
    logic [31:0] v;
    wr(A_TXD, 32'hA5);
    wait_bytes(1);
    check("R9 mosi msb first", {24'd0, mon_sh}, 32'hA5);
    rd(A_STAT, v); check("R2 status after byte", v, 32'h4);
    rd(A_FLAG, v); check("R7 flags sent+not empty", v, 32'h104);
    rd(A_RXD, v);  check("R9 sampled reply", v, 32'h5A);
    rd(A_RXD, v);  check("R8 empty read", v, 32'hDEADBEEF);
  endtask

  task automatic t_flags;
    logic [31:0] v;
    wr(A_FLAG, 32'h104); rd(A_FLAG, v); check("R6 toggle clears", v, 32'h0);
    wr(A_FLAG, 32'h001); rd(A_FLAG, v); check("R6 unimplemented bit", v, 32'h0);
    wr(A_FLAG, 32'h004); rd(A_FLAG, v); check("R6 toggle sets", v, 32'h4);
    wr(A_IEN, 32'h4); @(negedge clk);
    check("R7 no global enable", {31'd0, irq}, 32'h0);
    wr(A_GIE, 32'h8000_0000); @(negedge clk);
    check("R7 irq asserted", {31'd0, irq}, 32'h1);
    rd(A_GIE, v); check("R7 global readback", v, 32'h8000_0000);
    wr(A_IEN, 32'h10); @(negedge clk);
    check("R7 enable mismatch", {31'd0, irq}, 32'h0);
    wr(A_FLAG, 32'h004); wr(A_IEN, 32'h0); wr(A_GIE, 32'h0);
  endtask

  task automatic t_hold;
    logic [31:0] v;
    wr(A_CTRL, 32'h100);
    wr(A_TXD, 32'h11); wr(A_TXD, 32'h22); wr(A_TXD, 32'h33);
    wait_bytes(4);
    rd(A_STAT, v); check("R3 held, nothing sent", v, 32'h1);
    rd(A_CTRL, v); check("R3 hold readback", v, 32'h100);
    wr(A_CTRL, 32'h0);
    wait_bytes(3);
    rd(A_RXD, v); check("R3 first", v, 32'hEE);
    rd(A_RXD, v); check("R3 second", v, 32'hDD);
    rd(A_RXD, v); check("R3 third", v, 32'hCC);
  endtask

  task automatic t_fill;
    logic [31:0] v;
    wr(A_CTRL, 32'h100);
    for (int i = 0; i < 256; i++) wr(A_TXD, i);
    rd(A_STAT, v); check("R11 tx full", v, 32'h9);
    wr(A_TXD, 32'hEE);
    wr(A_CTRL, 32'h0);
    wait_bytes(256);
    rd(A_STAT, v); check("R2 rx full", v, 32'h6);
    wr(A_TXD, 32'h77);
    wait_bytes(1);
    rd(A_FLAG, v); check("R8 full and overrun flags", v & 32'h30, 32'h30);
    for (int i = 0; i < 256; i++) begin
      rd(A_RXD, v); check("R8 kept byte", v, {24'd0, ~i[7:0]});
    end
    rd(A_RXD, v); check("R11 extra byte dropped", v, 32'hDEADBEEF);
  endtask

  task automatic t_flush;
    logic [31:0] v;
    wr(A_CTRL, 32'h100);
    wr(A_TXD, 32'h01); wr(A_TXD, 32'h02);
    wr(A_CTRL, 32'h120);
    rd(A_STAT, v); check("R10 tx emptied", v, 32'h5);
    rd(A_CTRL, v); check("R10 bit 5 not stored", v, 32'h100);
    wr(A_CTRL, 32'h0);
    wait_bytes(2);
    rd(A_STAT, v); check("R10 flushed bytes not sent", v, 32'h5);
    wr(A_TXD, 32'h3C);
    wait_bytes(1);
    rd(A_STAT, v); check("R10 one received", v, 32'h4);
    wr(A_CTRL, 32'h40);
    rd(A_STAT, v); check("R10 rx emptied", v, 32'h5);
    rd(A_CTRL, v); check("R10 bit 6 not stored", v, 32'h0);
  endtask

  task automatic t_select;
    logic [31:0] v;
    wr(A_SEL, 32'h6); @(negedge clk);
    check("R5 pins follow", {28'd0, spi_ss_n}, 32'h6);
    wr(A_SEL, 32'h5); wr(A_IEN, 32'h4);
    wr(A_SRST, 32'h3);
    rd(A_SEL, v); check("R4 wrong key ignored", v, 32'h5);
    rd(A_IEN, v); check("R4 wrong key keeps enable", v, 32'h4);
    wr(A_CTRL, 32'h100); wr(A_TXD, 32'h99);
    wr(A_SRST, 32'hA);
    rd(A_SEL, v); check("R4 select reset", v, 32'hF);
    rd(A_IEN, v); check("R4 enable reset", v, 32'h0);
    rd(A_STAT, v); check("R4 queues reset", v, 32'h5);
    rd(A_CTRL, v); check("R4 control reset", v, 32'h0);
    check("R5 pins after soft reset", {28'd0, spi_ss_n}, 32'hF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_basic;
    t_flags;
    t_hold;
    t_fill;
    t_flush;
    t_select;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule